// File: doc/BRIEF.md
# Framed Synchronous Serial Master

This block is a general-purpose synchronous serial master. Software programs a control word and then writes a transmit word; the block shifts that word out on a data pin while it shifts a word of the same length in from a second data pin. It drives its own serial clock, derived from the base clock by an even divider, and a frame strobe. The strobe's polarity and its start and end positions are programmable, counted in base clocks from the first cycle of the transfer.

Word length (1 to 32 bits), bit order, serial clock polarity and a leading delay before the first bit are all taken from the control word. The control word is copied when a transfer starts. A later control write therefore affects only the next transfer, not the one in flight. When the last bit has been sampled, the busy flag drops, a one-cycle done strobe is raised and the received word becomes readable. The block moves one word per transmit write and has no queueing.

Top module: `frame_ssp`

## Requirements
- R1: After reset, busy, done, the serial clock and the data output are 0, the received word is 0, and the frame output is 1 because the reset control word selects an active-low frame.
- R2: A transmit write that lands while control bit 31 is 1 and no transfer is running starts a transfer. Busy rises in the next cycle and stays high for exactly D + N·2·(F+1) cycles. D is the delay field, N is the word length and F is the divider field.
- R3: A transmit write made while a transfer is running, or while bit 31 is 0, starts nothing and does not change the word being sent.
- R4: The serial clock rests at the level of control bit 29 while idle and during the delay. Each bit then spends F+1 cycles at that level followed by F+1 cycles at the opposite level, so the clock runs at the base clock divided by 2·(F+1). The divider field is bits 5:0.
- R5: Control bit 30 sets the bit order: 1 sends the most significant bit first and 0 sends the least significant bit first. The data output presents the first bit from the first busy cycle, changes only at the start of each bit, and is 0 while idle.
- R6: The input pin is sampled on the base-clock edge at which the serial clock leaves its resting level. Received bits are stored in the same bit-order positions as the transmit bits, and bits at or above N are 0.
- R7: Control bits 28:24 hold N−1, so a value of 0 gives a 1-bit word and a value of 31 gives a 32-bit word.
- R8: Control bits 17:13 hold D, the number of base clocks with the serial clock at rest before the first bit period begins.
- R9: Counting the first busy cycle as 0, the frame output is active from count S (bits 11:6) up to, but not including, count E (bits 23:18). If E ≤ S, it is active for count S only. Bit 12 sets the active level, with 1 meaning active-high. The output is inactive while idle.
- R10: In the first cycle after busy falls, done is high for exactly one cycle and the received word is updated. The received word holds its value at all other times.
- R11: A control write during a transfer changes neither its timing nor its data. The new word takes effect at the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctrl_we | input | 1 | Control word write strobe |
| ctrl_wdata | input | 32 | Control word |
| tx_we | input | 1 | Transmit word write strobe |
| tx_wdata | input | 32 | Transmit word |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle end-of-transfer strobe |
| rx_data | output | 32 | Last received word |
| ssp_sck | output | 1 | Serial clock |
| ssp_sdo | output | 1 | Serial data out |
| ssp_frm | output | 1 | Frame strobe |
| ssp_sdi | input | 1 | Serial data in |

## Verification
A transmit write sampled at one clock edge shows up as busy, the serial clock, the first data bit and a frame starting at count 0, all visible right after that same edge. The received word and the done strobe appear D + N·2·(F+1) edges later. The bench keeps a behavioural model that advances one step per edge, using an integer transfer count and the copied control word. It compares every output at the falling edge, so each result is checked in the exact cycle it is due. Directed checks also count the busy cycles of each transfer against the length formula. These include transfers disturbed by extra writes in the middle, and back-to-back transfers.

// File: rtl/frame_ssp_pkg.sv
// Package: shared widths, control word layout and sequencer state type.
// Assumes a 32-bit control word; field positions below are the block's
// contract with software.
package frame_ssp_pkg;
    localparam int WLEN_W = 5;                 // word length field width
    localparam int POS_W  = 6;                 // frame position field width
    localparam int DLY_W  = 5;                 // initial delay field width
    localparam int DIV_W  = 6;                 // divider field width
    localparam int DATA_W = 2 ** WLEN_W;       // widest word

    typedef struct packed {
        logic              en;         // 31
        logic              msb_first;  // 30
        logic              cpol;       // 29
        logic [WLEN_W-1:0] wlen_m1;    // 28:24
        logic [POS_W-1:0]  frm_end;    // 23:18
        logic [DLY_W-1:0]  delay;      // 17:13
        logic              frm_pol;    // 12
        logic [POS_W-1:0]  frm_start;  // 11:6
        logic [DIV_W-1:0]  div;        // 5:0
    } ssp_cfg_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_DELAY = 2'd1,
        ST_SHIFT = 2'd2
    } ssp_state_t;
endpackage

// File: rtl/frame_ssp_timing.sv
// Module: transfer sequencer. Runs the delay period, then N bit periods of
// 2*(div+1) base clocks each, and produces the serial clock, the bit index
// and the sample/finish strobes.
// Assumes the configuration inputs are stable while busy.
module frame_ssp_timing
    import frame_ssp_pkg::*;
#(
    parameter int DIV_W_P = DIV_W,
    parameter int DLY_W_P = DLY_W,
    parameter int IDX_W   = WLEN_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [DLY_W_P-1:0] delay,
    input  logic [DIV_W_P-1:0] div,
    input  logic [IDX_W-1:0]   last_idx,
    input  logic               cpol,
    output logic               busy,
    output logic               sck,
    output logic [IDX_W-1:0]   bit_idx,
    output logic               sample_stb,
    output logic               finish_stb
);
    localparam logic [DLY_W_P-1:0] DLY_ONE = 1;
    localparam logic [DIV_W_P-1:0] DIV_ONE = 1;
    localparam logic [IDX_W-1:0]   IDX_ONE = 1;

    ssp_state_t         st;
    logic [DLY_W_P-1:0] dcnt;
    logic [DIV_W_P-1:0] hcnt;
    logic               half;
    logic [IDX_W-1:0]   bcnt;
    logic               half_end;

    // End of a half bit period.
    assign half_end   = (st == ST_SHIFT) && (hcnt == div);
    assign sample_stb = half_end && !half;
    assign finish_stb = half_end && half && (bcnt == last_idx);
    assign busy       = (st != ST_IDLE);
    assign bit_idx    = bcnt;
    // The clock leaves its resting level only in the second half of a bit.
    assign sck        = cpol ^ ((st == ST_SHIFT) && half);

    // Sequencer state and counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st   <= ST_IDLE;
            dcnt <= '0;
            hcnt <= '0;
            half <= 1'b0;
            bcnt <= '0;
        end else begin
            case (st)
                ST_IDLE: begin
                    if (start) begin
                        st   <= (delay != '0) ? ST_DELAY : ST_SHIFT;
                        dcnt <= '0;
                        hcnt <= '0;
                        half <= 1'b0;
                        bcnt <= '0;
                    end
                end
                ST_DELAY: begin
                    if (dcnt == delay - DLY_ONE) st <= ST_SHIFT;
                    else                         dcnt <= dcnt + DLY_ONE;
                end
                ST_SHIFT: begin
                    if (hcnt == div) begin
                        hcnt <= '0;
                        half <= ~half;
                        if (half) begin
                            if (bcnt == last_idx) st <= ST_IDLE;
                            else                  bcnt <= bcnt + IDX_ONE;
                        end
                    end else begin
                        hcnt <= hcnt + DIV_ONE;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/frame_ssp_frame.sv
// Module: frame strobe generator. Counts base clocks from the start of a
// transfer (saturating) and drives the strobe active inside [start, end),
// or for the single count 'start' when end <= start.
// Assumes position inputs are stable while busy.
module frame_ssp_frame
    import frame_ssp_pkg::*;
#(
    parameter int POS_W_P = POS_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic               busy,
    input  logic               pol,
    input  logic [POS_W_P-1:0] pos_start,
    input  logic [POS_W_P-1:0] pos_end,
    output logic               frm
);
    localparam int              FCNT_W   = POS_W_P + 1;
    localparam logic [FCNT_W-1:0] FCNT_MAX = '1;
    localparam logic [FCNT_W-1:0] FCNT_ONE = 1;

    logic [FCNT_W-1:0] fcnt;
    logic [FCNT_W-1:0] s_ext;
    logic [FCNT_W-1:0] e_eff;
    logic              hit;

    // Effective window bounds.
    assign s_ext = {1'b0, pos_start};
    assign e_eff = (pos_end > pos_start) ? {1'b0, pos_end} : s_ext + FCNT_ONE;
    assign hit   = busy && (fcnt >= s_ext) && (fcnt < e_eff);
    assign frm   = hit ? pol : ~pol;

    // Base-clock count since transfer start.
    always_ff @(posedge clk) begin
        if (!rst_n)                        fcnt <= '0;
        else if (start)                    fcnt <= '0;
        else if (busy && fcnt != FCNT_MAX) fcnt <= fcnt + FCNT_ONE;
    end
endmodule

// File: rtl/frame_ssp_shift.sv
// Module: full-duplex data path. Holds the transmit word, selects the bit
// to drive by index and order, gathers received bits into the same
// positions and publishes the received word at the end of a transfer.
// Assumes bit_idx never exceeds last_idx.
module frame_ssp_shift
    import frame_ssp_pkg::*;
#(
    parameter int IDX_W = WLEN_W,
    localparam int DW   = 2 ** IDX_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [DW-1:0]    tx_word,
    input  logic             busy,
    input  logic             msb_first,
    input  logic [IDX_W-1:0] last_idx,
    input  logic [IDX_W-1:0] bit_idx,
    input  logic             sample_stb,
    input  logic             finish_stb,
    input  logic             sdi,
    output logic             sdo,
    output logic [DW-1:0]    rx_word
);
    logic [DW-1:0]    tx_q;
    logic [DW-1:0]    rx_acc;
    logic [IDX_W-1:0] pos;

    // Wire position of the current bit.
    assign pos = msb_first ? (last_idx - bit_idx) : bit_idx;
    assign sdo = busy & tx_q[pos];

    // Transmit word capture.
    always_ff @(posedge clk) begin
        if (!rst_n)     tx_q <= '0;
        else if (start) tx_q <= tx_word;
    end

    // Receive assembly and publication.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_acc  <= '0;
            rx_word <= '0;
        end else begin
            if (start)           rx_acc      <= '0;
            else if (sample_stb) rx_acc[pos] <= sdi;
            if (finish_stb)      rx_word     <= rx_acc;
        end
    end
endmodule

// File: rtl/frame_ssp.sv
// Module: framed synchronous serial master top. Holds the control word,
// copies it at transfer start, and joins sequencer, frame and data path.
// Assumes one word per transmit write; writes while busy are dropped.
module frame_ssp
    import frame_ssp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_we,
    input  logic [31:0]       ctrl_wdata,
    input  logic              tx_we,
    input  logic [DATA_W-1:0] tx_wdata,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rx_data,
    output logic              ssp_sck,
    output logic              ssp_sdo,
    output logic              ssp_frm,
    input  logic              ssp_sdi
);
    ssp_cfg_t          ctrl_q;
    ssp_cfg_t          cfg_q;
    ssp_cfg_t          cfg_use;
    logic              start;
    logic [WLEN_W-1:0] bit_idx;
    logic              sample_stb;
    logic              finish_stb;

    // Live word when idle, frozen copy during a transfer.
    assign cfg_use = busy ? cfg_q : ctrl_q;
    assign start   = tx_we && cfg_use.en && !busy;

    // Software control word.
    always_ff @(posedge clk) begin
        if (!rst_n)       ctrl_q <= '0;
        else if (ctrl_we) ctrl_q <= ssp_cfg_t'(ctrl_wdata);
    end

    // Per-transfer configuration copy.
    always_ff @(posedge clk) begin
        if (!rst_n)     cfg_q <= '0;
        else if (start) cfg_q <= ctrl_q;
    end

    // Completion strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) done <= 1'b0;
        else        done <= finish_stb;
    end

    frame_ssp_timing #(.DIV_W_P(DIV_W), .DLY_W_P(DLY_W), .IDX_W(WLEN_W)) u_timing (
        .clk(clk), .rst_n(rst_n), .start(start),
        .delay(cfg_use.delay), .div(cfg_use.div), .last_idx(cfg_use.wlen_m1),
        .cpol(cfg_use.cpol), .busy(busy), .sck(ssp_sck), .bit_idx(bit_idx),
        .sample_stb(sample_stb), .finish_stb(finish_stb)
    );

    frame_ssp_frame #(.POS_W_P(POS_W)) u_frame (
        .clk(clk), .rst_n(rst_n), .start(start), .busy(busy),
        .pol(cfg_use.frm_pol), .pos_start(cfg_use.frm_start),
        .pos_end(cfg_use.frm_end), .frm(ssp_frm)
    );

    frame_ssp_shift #(.IDX_W(WLEN_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .start(start), .tx_word(tx_wdata),
        .busy(busy), .msb_first(cfg_use.msb_first), .last_idx(cfg_use.wlen_m1),
        .bit_idx(bit_idx), .sample_stb(sample_stb), .finish_stb(finish_stb),
        .sdi(ssp_sdi), .sdo(ssp_sdo), .rx_word(rx_data)
    );
endmodule

// File: rtl/frame_ssp_checker.sv
// Module: property checker for frame_ssp, attached by bind.
// Assumes the live control fields are brought out of the top.
module frame_ssp_checker #(
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          tx_we,
    input logic          busy,
    input logic          done,
    input logic [DW-1:0] rx_data,
    input logic          sck,
    input logic          sdo,
    input logic          frm,
    input logic          en_live,
    input logic          cpol_live,
    input logic          fpol_live
);
    AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_we && en_live && !busy) |=> busy); // R2
    AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy))); // R10
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R10
    AST_RX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(rx_data)); // R10
    AST_IDLE_SCK: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (sck == cpol_live)); // R4
    AST_IDLE_SDO: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !sdo); // R5
    AST_IDLE_FRM: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (frm == ~fpol_live)); // R9
endmodule

bind frame_ssp frame_ssp_checker #(.DW(frame_ssp_pkg::DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .tx_we(tx_we), .busy(busy), .done(done),
    .rx_data(rx_data), .sck(ssp_sck), .sdo(ssp_sdo), .frm(ssp_frm),
    .en_live(ctrl_q.en), .cpol_live(ctrl_q.cpol), .fpol_live(ctrl_q.frm_pol)
);

// File: tb/frame_ssp_test.sv
// Bench: behavioural per-edge model of the serial master, compared with
// every output at each falling edge, plus directed busy-length checks.
module frame_ssp_test;
    import frame_ssp_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctrl_we = 1'b0;
    logic [31:0] ctrl_wdata = '0;
    logic        tx_we = 1'b0;
    logic [31:0] tx_wdata = '0;
    logic        sdi = 1'b0;
    logic        busy, done, sck, sdo, frm;
    logic [31:0] rx_data;

    always #4 clk = ~clk;

    frame_ssp uut (
        .clk(clk), .rst_n(rst_n), .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
        .tx_we(tx_we), .tx_wdata(tx_wdata), .busy(busy), .done(done),
        .rx_data(rx_data), .ssp_sck(sck), .ssp_sdo(sdo), .ssp_frm(frm),
        .ssp_sdi(sdi)
    );

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;

    // Model state.
    int          t = 0;
    bit          m_busy = 0, m_done = 0;
    logic [31:0] m_rx = '0, m_acc = '0, m_tx = '0;
    ssp_cfg_t    live = '0, snap = '0;

    task automatic check1(input string rq, input string nm,
                          input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h at %0t", rq, nm, act, exp, $time);
        end
    endtask

    function automatic int xfer_len(input ssp_cfg_t c);
        return int'(c.delay) + (int'(c.wlen_m1) + 1) * 2 * (int'(c.div) + 1);
    endfunction

    function automatic logic [31:0] mk(input bit en, input bit msb, input bit cpol,
            input int wl, input int fe, input int dly, input bit fpol,
            input int fs, input int dv);
        return {en, msb, cpol, 5'(wl), 6'(fe), 5'(dly), fpol, 6'(fs), 6'(dv)};
    endfunction

    // Reference model, one step per rising edge.
    always @(posedge clk) begin : model
        int h, len, p, i, pos;
        if (!rst_n) begin
            t = 0; m_busy = 0; m_done = 0; m_rx = '0; m_acc = '0; m_tx = '0;
            live = '0; snap = '0;
        end else begin
            m_done = 0;
            if (m_busy) begin
                h = int'(snap.div) + 1;
                len = xfer_len(snap);
                if (t >= int'(snap.delay)) begin
                    p = (t - int'(snap.delay)) % (2 * h);
                    if (p == h - 1) begin
                        i = (t - int'(snap.delay)) / (2 * h);
                        pos = snap.msb_first ? int'(snap.wlen_m1) - i : i;
                        m_acc[pos] = sdi;
                    end
                end
                t++;
                if (t == len) begin
                    m_busy = 0; m_done = 1; m_rx = m_acc;
                end
            end else if (tx_we && live.en) begin
                snap = live; t = 0; m_busy = 1; m_acc = '0; m_tx = tx_wdata;
            end
            if (ctrl_we) live = ssp_cfg_t'(ctrl_wdata);
        end
    end

    // Compare every output away from the active edge.
    always @(negedge clk) begin : compare
        ssp_cfg_t c;
        int h, p, i, pos, fe;
        logic e_sck, e_sdo, e_frm;
        if (!finished) begin
            if (m_busy) begin
                c = snap;
                h = int'(c.div) + 1;
                if (t < int'(c.delay)) begin
                    e_sck = c.cpol; i = 0;
                end else begin
                    p = (t - int'(c.delay)) % (2 * h);
                    i = (t - int'(c.delay)) / (2 * h);
                    e_sck = (p < h) ? c.cpol : ~c.cpol;
                end
                pos = c.msb_first ? int'(c.wlen_m1) - i : i;
                e_sdo = m_tx[pos];
                fe = (c.frm_end > c.frm_start) ? int'(c.frm_end) : int'(c.frm_start) + 1;
                e_frm = (t >= int'(c.frm_start) && t < fe) ? c.frm_pol : ~c.frm_pol;
            end else begin
                e_sck = live.cpol; e_sdo = 1'b0; e_frm = ~live.frm_pol;
            end
            if (!rst_n) begin
                check1("R1", "busy", 32'(busy), 32'(m_busy));
                check1("R1", "frm", 32'(frm), 32'(e_frm));
                check1("R1", "rx", rx_data, m_rx);
            end else begin
                check1("R2", "busy", 32'(busy), 32'(m_busy));
                check1("R10", "done", 32'(done), 32'(m_done));
                check1("R6", "rx", rx_data, m_rx);
                check1("R4", "sck", 32'(sck), 32'(e_sck));
                check1("R5", "sdo", 32'(sdo), 32'(e_sdo));
                check1("R9", "frm", 32'(frm), 32'(e_frm));
            end
        end
    end

    // Serial input stimulus, changed away from the rising edge.
    always @(negedge clk) begin
        #2 sdi = 1'(($urandom) & 1);
    end

    task automatic wr_ctrl(input logic [31:0] v);
        ctrl_wdata = v; ctrl_we = 1'b1;
        @(negedge clk); #1 ctrl_we = 1'b0;
    endtask

    // Issue one transfer and count its busy cycles; optional mid-transfer pokes.
    task automatic xfer(input string rq, input logic [31:0] w, input int exp_len,
                        input bit poke_tx, input bit poke_ctrl, input logic [31:0] nc);
        int cnt;
        cnt = 0;
        tx_wdata = w; tx_we = 1'b1;
        @(negedge clk); #1 tx_we = 1'b0;
        while (busy) begin
            cnt++;
            if (cnt == 3) begin
                if (poke_tx) begin tx_wdata = ~w; tx_we = 1'b1; end
                if (poke_ctrl) begin ctrl_wdata = nc; ctrl_we = 1'b1; end
            end
            @(negedge clk); #1;
            tx_we = 1'b0; ctrl_we = 1'b0;
        end
        check1(rq, "busy_len", 32'(cnt), 32'(exp_len));
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finished = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin : main
        logic [31:0] cA, cB, cC, cD, cH;
        repeat (3) @(negedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk); #1;
        // R2 basic: LSB first, fastest clock, no delay
        cA = mk(1, 0, 0, 7, 0, 0, 0, 0, 0);
        wr_ctrl(cA);
        xfer("R2", 32'hA5, xfer_len(ssp_cfg_t'(cA)), 0, 0, '0);
        // R8 delay, MSB first, inverted clock, active-high frame window
        cB = mk(1, 1, 1, 7, 10, 3, 1, 2, 1);
        wr_ctrl(cB);
        xfer("R8", 32'h3C, xfer_len(ssp_cfg_t'(cB)), 0, 0, '0);
        // R7 full 32-bit word, frame end below start
        cC = mk(1, 1, 0, 31, 3, 2, 0, 5, 2);
        wr_ctrl(cC);
        xfer("R7", 32'hDEADBEEF, xfer_len(ssp_cfg_t'(cC)), 0, 0, '0);
        // R7 single-bit word
        cD = mk(1, 0, 1, 0, 1, 0, 1, 0, 0);
        wr_ctrl(cD);
        xfer("R7", 32'h1, xfer_len(ssp_cfg_t'(cD)), 0, 0, '0);
        // R3 transmit write while busy is dropped
        wr_ctrl(cB);
        xfer("R3", 32'h96, xfer_len(ssp_cfg_t'(cB)), 1, 0, '0);
        // R11 control write mid-transfer leaves the transfer alone
        wr_ctrl(cC);
        xfer("R11", 32'h12345678, xfer_len(ssp_cfg_t'(cC)), 0, 1, mk(1, 0, 1, 3, 0, 0, 1, 0, 5));
        repeat (2) @(negedge clk); #1;
        // R3 write while disabled starts nothing
        wr_ctrl(mk(0, 0, 0, 7, 0, 0, 0, 0, 0));
        tx_wdata = 32'hFF; tx_we = 1'b1;
        @(negedge clk); #1 tx_we = 1'b0;
        repeat (2) @(negedge clk); #1;
        check1("R3", "busy_disabled", 32'(busy), 32'h0);
        // R9 slowest clock, single-count frame at count 63
        cH = mk(1, 0, 0, 7, 0, 0, 0, 63, 63);
        wr_ctrl(cH);
        xfer("R9", 32'h5A, xfer_len(ssp_cfg_t'(cH)), 0, 0, '0);
        // R10 back-to-back transfers, second issued in the done cycle
        wr_ctrl(cA);
        xfer("R10", 32'h81, xfer_len(ssp_cfg_t'(cA)), 0, 0, '0);
        xfer("R10", 32'h7E, xfer_len(ssp_cfg_t'(cA)), 0, 0, '0);
        repeat (4) @(negedge clk);
        finished = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule